// File: doc/BRIEF.md
# Ticket Tag Memory Access Controller

This block is the hardwired command engine of a throw-away contactless ticket tag. A front end that is not part of this block has already removed framing and checksums from each reader command. It passes the block an opcode, a page or index byte and a 32-bit argument. The engine keeps the tag's idle, active and halted state. It serves page reads and single-page writes from a small register-based memory. It compares an unencrypted password against a stored value to unlock a protected upper region. It enforces per-page lock bits that can only ever be set, and it keeps a bank of counters that can only move upward.

Commands enter on a valid/ready stream and each accepted command produces exactly one response on a second valid/ready stream. A response carries a 4-bit status code and a 128-bit data field. Only one command can be outstanding. `cmd_ready` is low from the cycle a response becomes valid until the consumer takes it with `rsp_ready`, and while a response waits its code and data stay frozen. Reset models the power-up of a blank ticket: memory, locks and counters clear, the fixed identifier pages keep their factory value, and the tag sits idle.

Top module: `tkt_mem_ctrl`

## Requirements
- R1: After reset `rsp_valid` is 0, `cmd_ready` is 1, the tag is idle, and all user pages and counters read as zero once the tag is woken.
- R2: With `LARGE`=0 there are 14 pages (2 identifier pages plus 48 user bytes); with `LARGE`=1 there are 29. A READ, WRITE or LOCK naming page >= the page count returns code 0x0.
- R3: Pages 0 and 1 hold the 7-byte identifier: page 0 = bytes 0..3 (byte 0 in bits 7:0), page 1 = bytes 4..6 with a zero top byte. They read back unchanged, and a WRITE to either returns 0x5 and has no effect.
- R4: WAKE (0x52) always answers 0xA and makes the tag active. HALT (0x50) is allowed only when active; it moves the tag to halted and drops any authentication. READ, WRITE, PWD, LOCK, RDCNT and INCR outside the active state, and HALT outside it, return 0x1.
- R5: READ (0x30) returns four consecutive pages starting at the given page, wrapping from the last page to page 0. The first page is in data bits 31:0 and the fourth in bits 127:96.
- R6: WRITE (0xA2) stores `cmd_arg` into exactly one page (arg bits 7:0 become byte 0) and answers 0xA.
- R7: PWD (0x1B) answers 0xA and authenticates when `cmd_arg` equals the stored password; on a mismatch it answers 0x4 and clears authentication. Without authentication, a READ whose four-page window touches a page >= `PROT_PAGE`, or a WRITE or LOCK of such a page, returns 0x4.
- R8: LOCK (0x2C) sets the lock bit of one page and answers 0xA. Lock bits are never cleared, and a WRITE to a locked page returns 0x5 and leaves the page unchanged.
- R9: RDCNT (0x39) with index 0..2 answers 0xA with the 24-bit counter value in data bits 23:0. An index >= 3 returns 0x0.
- R10: INCR (0xA5) adds `cmd_arg[23:0]` to the indexed counter and answers 0xA. If the sum would exceed 0xFFFFFF it answers 0x6 and the counter keeps its value, so a counter never decreases.
- R11: An opcode outside the set above returns 0x0.
- R12: A response is valid in the cycle after its command is accepted, and it holds its code and data while `rsp_ready` is low. `cmd_ready` stays low until the response is taken. The data field is zero on every response other than a successful READ or RDCNT.
- R13: When several checks fail, the code reflects the first failure in this order: state, page or index range, authentication, lock, counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models tag power-up |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_op | input | 8 | Command opcode |
| cmd_page | input | 8 | Page number or counter index |
| cmd_arg | input | 32 | Write data, password or increment amount |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_code | output | 4 | Status: 0xA acknowledge, otherwise a refusal code |
| rsp_data | output | 128 | Read window or counter value |

## Verification
On every cycle the bound checker enforces the following rules. A waiting response must keep its code and data, and every accepted command must yield a response in the following cycle. No counter may ever decrease, no lock bit may ever clear, and the halted state never carries authentication. A write aimed at a locked page must never be acknowledged. Only the bench's scenarios show that the right code wins among competing failures, that the read window wraps and places bytes as specified, and that a refused write or a rejected overflowing increment leaves the stored value untouched, which is seen by reading it back. They also show that authentication is lost across a halt and wake.

// File: rtl/tkt_pkg.sv
package tkt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HALTED = 2'd2
  } tag_state_t;

  // command opcodes
  localparam logic [7:0] OP_WAKE  = 8'h52;
  localparam logic [7:0] OP_HALT  = 8'h50;
  localparam logic [7:0] OP_READ  = 8'h30;
  localparam logic [7:0] OP_WRITE = 8'hA2;
  localparam logic [7:0] OP_PWD   = 8'h1B;
  localparam logic [7:0] OP_LOCK  = 8'h2C;
  localparam logic [7:0] OP_RDCNT = 8'h39;
  localparam logic [7:0] OP_INCR  = 8'hA5;

  // response codes
  localparam logic [3:0] RC_ACK    = 4'hA;
  localparam logic [3:0] RC_BADARG = 4'h0;
  localparam logic [3:0] RC_STATE  = 4'h1;
  localparam logic [3:0] RC_AUTH   = 4'h4;
  localparam logic [3:0] RC_LOCKED = 4'h5;
  localparam logic [3:0] RC_OVF    = 4'h6;

  localparam int UID_PAGES = 2;
  localparam int PAGE_W    = 32;
  localparam int WIN_PAGES = 4;
  localparam int WIN_W     = PAGE_W * WIN_PAGES;

endpackage

// File: rtl/tkt_session.sv
module tkt_session
  import tkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_wake,
  input  logic       ev_halt,
  input  logic       ev_pwd_ok,
  input  logic       ev_pwd_bad,
  output tag_state_t state,
  output logic       auth
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      auth  <= 1'b0;
    end else begin
      if (ev_wake) begin
        state <= ST_ACTIVE;
      end else if (ev_halt) begin
        state <= ST_HALTED;
        auth  <= 1'b0;
      end else if (ev_pwd_ok) begin
        auth  <= 1'b1;
      end else if (ev_pwd_bad) begin
        auth  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tkt_page_store.sv
module tkt_page_store
  import tkt_pkg::*;
#(
  parameter int          USER_PAGES = 12,
  parameter int          NUM_PAGES  = 14,
  parameter int          PROT_PAGE  = 10,
  parameter logic [55:0] UID        = 56'h07_06_05_04_03_02_01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           sel_page,
  input  logic                 wr_en,
  input  logic [PAGE_W-1:0]    wr_data,
  input  logic                 lock_en,
  output logic [WIN_W-1:0]     rd_window,
  output logic                 rd_prot,
  output logic                 sel_locked,
  output logic [NUM_PAGES-1:0] lock_vec
);

  logic [PAGE_W-1:0]     user_mem [USER_PAGES];
  logic [USER_PAGES-1:0] user_lock;

  // identifier pages are permanently locked
  assign lock_vec = {user_lock, {UID_PAGES{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < USER_PAGES; u++) begin
        user_mem[u] <= '0;
      end
      user_lock <= '0;
    end else begin
      for (int u = 0; u < USER_PAGES; u++) begin
        if (sel_page == 8'(UID_PAGES + u)) begin
          if (wr_en && !user_lock[u]) begin
            user_mem[u] <= wr_data;
          end
          if (lock_en) begin
            user_lock[u] <= 1'b1;
          end
        end
      end
    end
  end

  // four-page read window with wrap-around
  logic [8:0]        idx;
  logic [PAGE_W-1:0] word;

  always_comb begin
    rd_window = '0;
    rd_prot   = 1'b0;
    idx       = '0;
    word      = '0;
    for (int k = 0; k < WIN_PAGES; k++) begin
      idx = {1'b0, sel_page} + 9'(k);
      if (idx >= 9'(NUM_PAGES)) begin
        idx = idx - 9'(NUM_PAGES);
      end
      word = '0;
      if (idx == 9'd0) begin
        word = UID[31:0];
      end else if (idx == 9'd1) begin
        word = {8'h00, UID[55:32]};
      end
      for (int u = 0; u < USER_PAGES; u++) begin
        if (idx == 9'(UID_PAGES + u)) begin
          word = user_mem[u];
        end
      end
      if (idx >= 9'(PROT_PAGE)) begin
        rd_prot = 1'b1;
      end
      rd_window[k*PAGE_W +: PAGE_W] = word;
    end
  end

  always_comb begin
    sel_locked = 1'b0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (sel_page == 8'(p)) begin
        sel_locked = lock_vec[p];
      end
    end
  end

endmodule

// File: rtl/tkt_counter_bank.sv
module tkt_counter_bank #(
  parameter int CNT_NUM = 3,
  parameter int CNT_W   = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               sel,
  input  logic                     inc_en,
  input  logic [CNT_W-1:0]         inc_amt,
  output logic                     sel_ok,
  output logic                     sel_ovf,
  output logic [CNT_W-1:0]         rd_val,
  output logic [CNT_NUM*CNT_W-1:0] cnt_flat
);

  logic [CNT_NUM-1:0] ovf_vec;

  for (genvar i = 0; i < CNT_NUM; i++) begin : g_cnt
    logic [CNT_W-1:0] val;
    logic [CNT_W:0]   sum;

    assign sum        = {1'b0, val} + {1'b0, inc_amt};
    assign ovf_vec[i] = sum[CNT_W];
    assign cnt_flat[i*CNT_W +: CNT_W] = val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val <= '0;
      end else if (inc_en && sel == 8'(i) && !sum[CNT_W]) begin
        val <= sum[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    sel_ok  = sel < 8'(CNT_NUM);
    sel_ovf = 1'b0;
    rd_val  = '0;
    for (int i = 0; i < CNT_NUM; i++) begin
      if (sel == 8'(i)) begin
        rd_val  = cnt_flat[i*CNT_W +: CNT_W];
        sel_ovf = ovf_vec[i];
      end
    end
  end

endmodule

// File: rtl/tkt_mem_ctrl.sv
module tkt_mem_ctrl
  import tkt_pkg::*;
#(
  parameter bit          LARGE     = 1'b0,
  parameter int          PROT_PAGE = 10,
  parameter int          CNT_NUM   = 3,
  parameter int          CNT_W     = 24,
  parameter logic [55:0] UID       = 56'h07_06_05_04_03_02_01,
  parameter logic [31:0] PASSWORD  = 32'hC0DE_1234
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [7:0]   cmd_op,
  input  logic [7:0]   cmd_page,
  input  logic [31:0]  cmd_arg,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [3:0]   rsp_code,
  output logic [127:0] rsp_data
);

  localparam int USER_BYTES = LARGE ? 108 : 48;
  localparam int USER_PAGES = USER_BYTES / (PAGE_W / 8);
  localparam int NUM_PAGES  = UID_PAGES + USER_PAGES;

  tag_state_t sess_state;
  logic       auth;
  logic       fire;

  logic wake_ev, halt_ev, pwd_ok_ev, pwd_bad_ev;
  logic wr_req, lock_req, inc_req;

  logic [WIN_W-1:0]     win_data;
  logic                 win_prot;
  logic                 page_locked;
  logic [NUM_PAGES-1:0] lock_vec;

  logic                     cnt_ok;
  logic                     cnt_ovf;
  logic [CNT_W-1:0]         cnt_val;
  logic [CNT_NUM*CNT_W-1:0] cnt_flat;

  logic [3:0]       nx_code;
  logic [WIN_W-1:0] nx_data;

  assign cmd_ready = !rsp_valid;
  assign fire      = cmd_valid && cmd_ready;

  tkt_session u_session (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_wake    (fire && wake_ev),
    .ev_halt    (fire && halt_ev),
    .ev_pwd_ok  (fire && pwd_ok_ev),
    .ev_pwd_bad (fire && pwd_bad_ev),
    .state      (sess_state),
    .auth       (auth)
  );

  tkt_page_store #(
    .USER_PAGES (USER_PAGES),
    .NUM_PAGES  (NUM_PAGES),
    .PROT_PAGE  (PROT_PAGE),
    .UID        (UID)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_page   (cmd_page),
    .wr_en      (fire && wr_req),
    .wr_data    (cmd_arg),
    .lock_en    (fire && lock_req),
    .rd_window  (win_data),
    .rd_prot    (win_prot),
    .sel_locked (page_locked),
    .lock_vec   (lock_vec)
  );

  tkt_counter_bank #(
    .CNT_NUM (CNT_NUM),
    .CNT_W   (CNT_W)
  ) u_counters (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (cmd_page),
    .inc_en   (fire && inc_req),
    .inc_amt  (cmd_arg[CNT_W-1:0]),
    .sel_ok   (cnt_ok),
    .sel_ovf  (cnt_ovf),
    .rd_val   (cnt_val),
    .cnt_flat (cnt_flat)
  );

  // command decode with fixed check priority:
  // state, range, authentication, lock, overflow
  logic active, page_ok, page_prot;

  always_comb begin
    active     = sess_state == ST_ACTIVE;
    page_ok    = cmd_page < 8'(NUM_PAGES);
    page_prot  = cmd_page >= 8'(PROT_PAGE);
    nx_code    = RC_BADARG;
    nx_data    = '0;
    wake_ev    = 1'b0;
    halt_ev    = 1'b0;
    pwd_ok_ev  = 1'b0;
    pwd_bad_ev = 1'b0;
    wr_req     = 1'b0;
    lock_req   = 1'b0;
    inc_req    = 1'b0;
    case (cmd_op)
      OP_WAKE: begin
        nx_code = RC_ACK;
        wake_ev = 1'b1;
      end
      OP_HALT: begin
        if (!active) nx_code = RC_STATE;
        else begin
          nx_code = RC_ACK;
          halt_ev = 1'b1;
        end
      end
      OP_READ: begin
        if (!active)                nx_code = RC_STATE;
        else if (!page_ok)          nx_code = RC_BADARG;
        else if (win_prot && !auth) nx_code = RC_AUTH;
        else begin
          nx_code = RC_ACK;
          nx_data = win_data;
        end
      end
      OP_WRITE: begin
        if (!active)                 nx_code = RC_STATE;
        else if (!page_ok)           nx_code = RC_BADARG;
        else if (page_prot && !auth) nx_code = RC_AUTH;
        else if (page_locked)        nx_code = RC_LOCKED;
        else begin
          nx_code = RC_ACK;
          wr_req  = 1'b1;
        end
      end
      OP_LOCK: begin
        if (!active)                 nx_code = RC_STATE;
        else if (!page_ok)           nx_code = RC_BADARG;
        else if (page_prot && !auth) nx_code = RC_AUTH;
        else begin
          nx_code  = RC_ACK;
          lock_req = 1'b1;
        end
      end
      OP_PWD: begin
        if (!active) nx_code = RC_STATE;
        else if (cmd_arg == PASSWORD) begin
          nx_code   = RC_ACK;
          pwd_ok_ev = 1'b1;
        end else begin
          nx_code    = RC_AUTH;
          pwd_bad_ev = 1'b1;
        end
      end
      OP_RDCNT: begin
        if (!active)      nx_code = RC_STATE;
        else if (!cnt_ok) nx_code = RC_BADARG;
        else begin
          nx_code = RC_ACK;
          nx_data = WIN_W'(cnt_val);
        end
      end
      OP_INCR: begin
        if (!active)      nx_code = RC_STATE;
        else if (!cnt_ok) nx_code = RC_BADARG;
        else if (cnt_ovf) nx_code = RC_OVF;
        else begin
          nx_code = RC_ACK;
          inc_req = 1'b1;
        end
      end
      default: nx_code = RC_BADARG;
    endcase
  end

  // response register, held until taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rsp_data  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_code  <= nx_code;
      rsp_data  <= nx_data;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/tkt_mem_ctrl_chk.sv
module tkt_mem_ctrl_chk #(
  parameter int NUM_PAGES = 14,
  parameter int CNT_NUM   = 3,
  parameter int CNT_W     = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic                     cmd_ready,
  input logic [7:0]               cmd_op,
  input logic [7:0]               cmd_page,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [3:0]               rsp_code,
  input logic [127:0]             rsp_data,
  input logic [1:0]               state,
  input logic                     auth,
  input logic [NUM_PAGES-1:0]     lock_vec,
  input logic [CNT_NUM*CNT_W-1:0] cnt_flat
);

  localparam logic [1:0] HALTED_ENC = 2'd2;
  localparam logic [7:0] WRITE_OP   = 8'hA2;
  localparam logic [3:0] ACK_CODE   = 4'hA;

  logic target_locked;
  always_comb begin
    target_locked = 1'b0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (cmd_page == 8'(p)) target_locked = lock_vec[p];
    end
  end

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_data));

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rsp_valid);

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vec & $past(lock_vec)) == $past(lock_vec));

  p_locked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == WRITE_OP && target_locked |=> rsp_code != ACK_CODE);

  p_halt_noauth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == HALTED_ENC |-> !auth);

  for (genvar i = 0; i < CNT_NUM; i++) begin : g_mono
    p_no_decrease_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[i*CNT_W +: CNT_W] >= $past(cnt_flat[i*CNT_W +: CNT_W]));
  end

endmodule

bind tkt_mem_ctrl tkt_mem_ctrl_chk #(
  .NUM_PAGES (NUM_PAGES),
  .CNT_NUM   (CNT_NUM),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_page  (cmd_page),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_code  (rsp_code),
  .rsp_data  (rsp_data),
  .state     (sess_state),
  .auth      (auth),
  .lock_vec  (lock_vec),
  .cnt_flat  (cnt_flat)
);

// File: tb/tkt_mem_ctrl_test.sv
`timescale 1ns/1ps
module tkt_mem_ctrl_test;

  localparam logic [55:0] T_UID = 56'h07_06_05_04_03_02_01;
  localparam logic [31:0] T_PWD = 32'hC0DE_1234;

  localparam logic [7:0] WAKE = 8'h52, HALT = 8'h50, RD = 8'h30, WR = 8'hA2;
  localparam logic [7:0] PWD = 8'h1B, LCK = 8'h2C, RDC = 8'h39, INC = 8'hA5;
  localparam logic [3:0] ACK = 4'hA, BAD = 4'h0, STA = 4'h1, AUT = 4'h4, LKD = 4'h5, OVF = 4'h6;

  localparam logic [127:0] UIDWIN = 128'h00000000_00000000_00070605_04030201;
  localparam logic [127:0] P23WIN = 128'h00000000_00000000_22222222_11111111;

  // {req, op, page, arg, code, data}
  localparam int NV = 30;
  localparam logic [187:0] VEC [NV] = '{
    {8'd4,  RD,   8'd0,  32'h0,        STA, 128'h0},   // R4 read while idle
    {8'd4,  WAKE, 8'd0,  32'h0,        ACK, 128'h0},   // R4
    {8'd3,  RD,   8'd0,  32'h0,        ACK, UIDWIN},   // R3 identifier layout
    {8'd3,  WR,   8'd0,  32'hDEADBEEF, LKD, 128'h0},   // R3 identifier read-only
    {8'd6,  WR,   8'd2,  32'h11111111, ACK, 128'h0},   // R6
    {8'd6,  WR,   8'd3,  32'h22222222, ACK, 128'h0},   // R6
    {8'd5,  RD,   8'd2,  32'h0,        ACK, P23WIN},   // R5
    {8'd2,  RD,   8'd14, 32'h0,        BAD, 128'h0},   // R2 page out of range
    {8'd7,  RD,   8'd9,  32'h0,        AUT, 128'h0},   // R7 window reaches protected
    {8'd7,  WR,   8'd10, 32'h5,        AUT, 128'h0},   // R7
    {8'd7,  PWD,  8'd0,  32'h12345678, AUT, 128'h0},   // R7 wrong password
    {8'd7,  PWD,  8'd0,  T_PWD,        ACK, 128'h0},   // R7
    {8'd7,  WR,   8'd13, 32'hDDDDDDDD, ACK, 128'h0},   // R7 protected write ok
    {8'd5,  RD,   8'd12, 32'h0,        ACK, 128'h00070605_04030201_DDDDDDDD_00000000}, // R5 wrap
    {8'd8,  LCK,  8'd3,  32'h0,        ACK, 128'h0},   // R8
    {8'd8,  WR,   8'd3,  32'h33333333, LKD, 128'h0},   // R8
    {8'd8,  RD,   8'd2,  32'h0,        ACK, P23WIN},   // R8 page kept
    {8'd10, INC,  8'd1,  32'h5,        ACK, 128'h0},   // R10
    {8'd9,  RDC,  8'd1,  32'h0,        ACK, 128'h5},   // R9
    {8'd10, INC,  8'd1,  32'hFFFFFA,   ACK, 128'h0},   // R10 reach max
    {8'd10, INC,  8'd1,  32'h1,        OVF, 128'h0},   // R10 overflow
    {8'd10, RDC,  8'd1,  32'h0,        ACK, 128'hFFFFFF}, // R10 value kept
    {8'd9,  RDC,  8'd3,  32'h0,        BAD, 128'h0},   // R9 bad index
    {8'd11, 8'h77, 8'd0, 32'h0,        BAD, 128'h0},   // R11
    {8'd4,  HALT, 8'd0,  32'h0,        ACK, 128'h0},   // R4
    {8'd4,  RD,   8'd2,  32'h0,        STA, 128'h0},   // R4
    {8'd4,  HALT, 8'd0,  32'h0,        STA, 128'h0},   // R4 halt when halted
    {8'd4,  WAKE, 8'd0,  32'h0,        ACK, 128'h0},   // R4
    {8'd4,  RD,   8'd10, 32'h0,        AUT, 128'h0},   // R4 auth lost by halt
    {8'd13, WR,   8'd1,  32'h0,        LKD, 128'h0}    // R13 lock beats nothing else here
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [7:0]   cmd_op = '0;
  logic [7:0]   cmd_page = '0;
  logic [31:0]  cmd_arg = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [3:0]   rsp_code;
  logic [127:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tkt_mem_ctrl #(
    .LARGE     (1'b0),
    .PROT_PAGE (10),
    .CNT_NUM   (3),
    .CNT_W     (24),
    .UID       (T_UID),
    .PASSWORD  (T_PWD)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_page  (cmd_page),
    .cmd_arg   (cmd_arg),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_code  (rsp_code),
    .rsp_data  (rsp_data)
  );

  task automatic chk(input int req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] pg, input logic [31:0] arg,
                         output logic [3:0] code, output logic [127:0] data, output logic vld);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op    = op;
    cmd_page  = pg;
    cmd_arg   = arg;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    vld  = rsp_valid;
    code = rsp_code;
    data = rsp_data;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0]   c;
    logic [127:0] d;
    logic         v;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk(1, "rsp_valid in reset", 128'(rsp_valid), 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, "rsp_valid after reset", 128'(rsp_valid), 128'h0);
    chk(1, "cmd_ready after reset", 128'(cmd_ready), 128'h1);

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i][179:172], VEC[i][171:164], VEC[i][163:132], c, d, v);
      chk(12, $sformatf("vec %0d valid", i), 128'(v), 128'h1);
      chk(int'(VEC[i][187:180]), $sformatf("vec %0d code", i), 128'(c), 128'(VEC[i][131:128]));
      chk(int'(VEC[i][187:180]), $sformatf("vec %0d data", i), d, VEC[i][127:0]);
    end

    // R2 lock out of range page
    run_cmd(LCK, 8'd14, 32'h0, c, d, v);
    chk(2, "lock page 14", 128'(c), 128'(BAD));

    // R13 range beats authentication: page 200 without auth
    run_cmd(WR, 8'd200, 32'h0, c, d, v);
    chk(13, "range before auth", 128'(c), 128'(BAD));

    // R12 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_op = RD; cmd_page = 8'd2; cmd_arg = '0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(12, "bp valid", 128'(rsp_valid), 128'h1);
    repeat (3) @(negedge clk);
    chk(12, "bp held valid", 128'(rsp_valid), 128'h1);
    chk(12, "bp ready low", 128'(cmd_ready), 128'h0);
    chk(12, "bp code", 128'(rsp_code), 128'(ACK));
    chk(12, "bp data", rsp_data, P23WIN);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(12, "bp released", 128'(rsp_valid), 128'h0);

    // R1 reset clears memory, locks and counters
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(1, "cmd_ready in reset", 128'(cmd_ready), 128'h1);
    rst_n = 1'b1;
    run_cmd(RD, 8'd2, 32'h0, c, d, v);
    chk(1, "idle after reset", 128'(c), 128'(STA));
    run_cmd(WAKE, 8'd0, 32'h0, c, d, v);
    run_cmd(RD, 8'd2, 32'h0, c, d, v);
    chk(1, "user pages cleared", d, 128'h0);
    run_cmd(RDC, 8'd1, 32'h0, c, d, v);
    chk(1, "counter cleared", d, 128'h0);
    run_cmd(WR, 8'd3, 32'h44444444, c, d, v);
    chk(1, "lock cleared by reset", 128'(c), 128'(ACK));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule